// File: doc/BRIEF.md
# Program/Erase Status Byte Generator

This block sits on the read path of a flash array controller. While the embedded program or erase engine is working, any read of the device must return a status byte instead of array contents. The block takes the engine state and the array read data and chooses what appears on the read data bus. It has a polling bit that reflects the target data, two bits that toggle from one read to the next, an error bit and an erase-timer bit. The reserved positions are driven low.

The toggle bits are held in two flip-flops inside the block. They flip on the clock edge that ends a read strobe, so each successive read returns the opposite value. Software can therefore tell whether the engine is still running, and whether it is suspended. The read data itself is combinational from the current inputs and the toggle state. When no status view applies, array data passes straight through, so the first read after completion returns real data.

Top module: `flash_status_gen`

## Requirements
- R1: When the engine is idle (engBusy=0, engSuspended=0), or suspended while the read address is outside the erasing blocks, rdData equals arrayData and statusActive is 0.
- R2: Bit 7 (polling) is the complement of targetBit7 during a busy program, 0 during a busy erase, and 1 on a suspended read of an erasing block.
- R3: Bit 6 starts at 0 after reset. While busy and not suspended, it inverts after each cycle with rdStrobe=1, so consecutive reads return opposite values.
- R4: While suspended, bit 6 stops toggling and reads return the same bit 6 value.
- R5: Bit 2 inverts after each read strobe whose address is in an erasing block, during a busy erase or during suspend. It holds on all other reads, including reads during a program.
- R6: Bit 5 equals engError during a busy operation and is 0 on suspended reads.
- R7: Bit 3 is 0 during a program. During a busy erase it is 0 while eraseWindowOpen=1 and 1 once the window has closed. It is 1 on suspended reads.
- R8: In status view, bits 0, 1 and 4 and every bit above 7 are 0.
- R9: statusActive is 1 exactly when rdData carries the status byte: the engine is busy and not suspended, or it is suspended and the address is in an erasing block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdStrobe | input | 1 | One cycle per read access |
| engBusy | input | 1 | Engine is running a program or erase |
| engIsErase | input | 1 | 1 for erase, 0 for program |
| engSuspended | input | 1 | Erase is suspended |
| eraseWindowOpen | input | 1 | Window for adding erase blocks is still open |
| engError | input | 1 | Engine reports failure |
| targetBit7 | input | 1 | Bit 7 of the data being programmed |
| addrInEraseBlk | input | 1 | Read address lies in a block selected for erase |
| arrayData | input | DATA_W | Array read data |
| rdData | output | DATA_W | Data returned to the reader |
| statusActive | output | 1 | rdData carries the status byte |

## Verification
The bench drives a program with both target values for bit 7, with and without the error flag, and interleaves cycles with and without strobes. This separates the strobe-driven flips from level-driven bits. The erase runs first with the block window open and then with it closed. Its reads alternate between addresses inside and outside the erasing blocks, which shows that bit 6 flips on every read while bit 2 flips only on erase-block reads. A suspend phase reads both kinds of address to show array passthrough, the frozen bit 6 and the still-moving bit 2. Completion is followed by a read that must return plain array data.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef struct packed {
    logic showStatus;
    logic suspendView;
    logic flipPoll;
    logic flipErase;
    logic pollVal;
    logic errVal;
    logic timerVal;
  } statCtl_t;
endpackage

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import flash_status_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rdStrobe,
  input  logic     engBusy,
  input  logic     engIsErase,
  input  logic     engSuspended,
  input  logic     eraseWindowOpen,
  input  logic     engError,
  input  logic     targetBit7,
  input  logic     addrInEraseBlk,
  output statCtl_t ctl
);
  logic busyView;
  logic suspendView;

  assign busyView    = engBusy && !engSuspended;
  assign suspendView = engSuspended && addrInEraseBlk;

  always_comb begin
    ctl.showStatus  = busyView || suspendView;
    ctl.suspendView = suspendView;
    ctl.flipPoll    = rdStrobe && busyView;
    ctl.flipErase   = rdStrobe && addrInEraseBlk &&
                      ((busyView && engIsErase) || engSuspended);
    if (busyView) begin
      ctl.pollVal  = engIsErase ? 1'b0 : !targetBit7;
      ctl.errVal   = engError;
      ctl.timerVal = engIsErase && !eraseWindowOpen;
    end else begin
      ctl.pollVal  = 1'b1;
      ctl.errVal   = 1'b0;
      ctl.timerVal = 1'b1;
    end
  end

  // R4
  suspend_no_poll_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    engSuspended |-> !ctl.flipPoll);

  // R5
  program_no_erase_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (engBusy && !engSuspended && !engIsErase) |-> !ctl.flipErase);
endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_POS = 7,
  parameter int TOGA_POS = 6,
  parameter int ERR_POS  = 5,
  parameter int TMR_POS  = 3,
  parameter int TOGB_POS = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  statCtl_t          ctl,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              statusActive
);
  logic pollTog;
  logic eraseTog;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollTog  <= 1'b0;
      eraseTog <= 1'b0;
    end else begin
      if (ctl.flipPoll)  pollTog  <= !pollTog;
      if (ctl.flipErase) eraseTog <= !eraseTog;
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      if (i == POLL_POS)      statusByte[i] = ctl.pollVal;
      else if (i == TOGA_POS) statusByte[i] = pollTog;
      else if (i == ERR_POS)  statusByte[i] = ctl.errVal;
      else if (i == TMR_POS)  statusByte[i] = ctl.timerVal;
      else if (i == TOGB_POS) statusByte[i] = eraseTog;
      else                    statusByte[i] = 1'b0;
    end
  end

  assign rdData       = ctl.showStatus ? statusByte : arrayData;
  assign statusActive = ctl.showStatus;

  // R3
  poll_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flipPoll |=> (pollTog != $past(pollTog)));

  // R4
  suspend_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.suspendView |=> $stable(pollTog));

  // R8
  reserved_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.showStatus |-> (rdData[0] == 1'b0 && rdData[1] == 1'b0 && rdData[4] == 1'b0));

  // R1
  passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusActive |-> (rdData == arrayData));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStrobe,
  input  logic              engBusy,
  input  logic              engIsErase,
  input  logic              engSuspended,
  input  logic              eraseWindowOpen,
  input  logic              engError,
  input  logic              targetBit7,
  input  logic              addrInEraseBlk,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] rdData,
  output logic              statusActive
);
  statCtl_t ctl;

  flash_status_ctl u_ctl (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .engBusy(engBusy),
    .engIsErase(engIsErase), .engSuspended(engSuspended),
    .eraseWindowOpen(eraseWindowOpen), .engError(engError),
    .targetBit7(targetBit7), .addrInEraseBlk(addrInEraseBlk), .ctl(ctl)
  );

  flash_status_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .arrayData(arrayData),
    .rdData(rdData), .statusActive(statusActive)
  );
endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdStrobe = 0, engBusy = 0, engIsErase = 0, engSuspended = 0;
  logic eraseWindowOpen = 0, engError = 0, targetBit7 = 0, addrInEraseBlk = 0;
  logic [7:0] arrayData = 8'h00;
  logic [7:0] rdData;
  logic statusActive;
  int nChecks = 0;
  int nFails = 0;
  int m6 = 0;
  int m2 = 0;
  bit done = 0;

  always #2 clk = !clk;

  flash_status_gen u0 (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .engBusy(engBusy),
    .engIsErase(engIsErase), .engSuspended(engSuspended),
    .eraseWindowOpen(eraseWindowOpen), .engError(engError),
    .targetBit7(targetBit7), .addrInEraseBlk(addrInEraseBlk),
    .arrayData(arrayData), .rdData(rdData), .statusActive(statusActive)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model toggle state
  always @(posedge clk) begin
    if (rstN && rdStrobe) begin
      if (engBusy && !engSuspended) m6 = 1 - m6;
      if (addrInEraseBlk && ((engBusy && !engSuspended && engIsErase) || engSuspended))
        m2 = 1 - m2;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic bit busyV = engBusy && !engSuspended;
      automatic bit suspV = engSuspended && addrInEraseBlk;
      chk("R9", statusActive, busyV || suspV);
      if (!busyV && !suspV) chk("R1", rdData, arrayData);
      else begin
        chk("R2", rdData[7], busyV ? (engIsErase ? 0 : !targetBit7) : 1);
        chk(suspV ? "R4" : "R3", rdData[6], m6);
        chk("R5", rdData[2], m2);
        chk("R6", rdData[5], busyV ? engError : 0);
        chk("R7", rdData[3], busyV ? (engIsErase && !eraseWindowOpen) : 1);
        chk("R8", {rdData[4], rdData[1], rdData[0]}, 0);
      end
    end
  end

  task automatic step(input bit strobe, input bit inBlk, input logic [7:0] d);
    @(posedge clk); #1;
    rdStrobe = strobe; addrInEraseBlk = inBlk; arrayData = d;
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    arrayData = 8'hA5;
    #1;
    chk("R1", rdData, 8'hA5);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 idle reads
    step(1, 0, 8'h3C); step(1, 1, 8'hFF);
    // program, target 1 then 0, error flag later
    engBusy = 1; targetBit7 = 1;
    for (int i = 0; i < 5; i++) step(i % 2, i % 3 == 0, 8'h81);
    targetBit7 = 0;
    for (int i = 0; i < 4; i++) step(1, 1, 8'h00);
    engError = 1;
    step(1, 0, 8'h55); step(0, 0, 8'h55);
    engError = 0; engBusy = 0;
    step(1, 0, 8'h9A); // R1 completion returns data
    // erase with window open then closed
    engBusy = 1; engIsErase = 1; eraseWindowOpen = 1;
    for (int i = 0; i < 4; i++) step(1, i % 2, 8'h11);
    eraseWindowOpen = 0;
    for (int i = 0; i < 6; i++) step(i != 2, i < 3, 8'h22);
    // suspend
    engSuspended = 1;
    for (int i = 0; i < 8; i++) step(1, i % 2, 8'h40 + 8'(i));
    step(0, 1, 8'h00);
    engSuspended = 0;
    for (int i = 0; i < 4; i++) step(1, i > 1, 8'h33);
    engError = 1;
    step(1, 1, 8'h33);
    engError = 0; engBusy = 0; engIsErase = 0;
    step(1, 1, 8'hC7); step(0, 0, 8'h7E);
    step(0, 0, 8'h7E);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule